// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Resumable Line Refill

This block is a read-only, direct-mapped cache between a requester and a slower next-level memory. The requester presents a byte address with a valid strobe. In the same cycle it receives one of three answers. A hit returns the 32-bit word. A miss returns a stall hint, and the requester is expected to retry later. An error reports that the refill of that line failed.

On a miss the cache keeps a refill record for the addressed set. The record first counts down the access latency. It then fetches the line one word at a time from the next level, with at most one word request outstanding across the whole cache. When the next level answers a word request with a stall, the record reloads its countdown with the reported count. Fetching then resumes at the word that stalled, so words already received are not fetched again. When the next level reports a bad address, the record latches an error. Once the last word arrives, the line is installed and the record is released.

Top module: `dmc_refill_cache`

## Requirements
- R1: A byte address is split as follows. The low log2(WORDS)+2 bits are the offset, and bits [OFF_W-1:2] select the word. The next log2(SETS) bits are the set index. The remaining upper bits are the tag. SETS and WORDS are powers of two, each at least 2.
- R2: A lookup hits only when the set's valid bit is set and its stored tag equals the request tag. A hit drives `rsp_kind`=1 with the addressed word in the same cycle. A tag match on an invalid line is a miss.
- R3: A miss on a set with no refill record answers `rsp_kind`=2 with `rsp_stall`=ACCESS_LAT. At that edge it opens a record holding the line base address and the request tag, with the countdown set to ACCESS_LAT, the word pointer set to 0 and no error.
- R4: A lookup that misses on a set whose record is open, with no error latched, answers `rsp_kind`=2 with `rsp_stall` equal to the current countdown. It has no other effect.
- R5: While a record has no word request in flight and its countdown is nonzero, the countdown drops by one each cycle. No word request is issued for that record until the countdown is 0.
- R6: Each word request is a one-cycle `nl_req_valid` pulse with address = line base + 4 × word pointer. At most one request is outstanding at any time. When several records are ready, the lowest set index goes first.
- R7: A data response (`nl_rsp_kind`=0) stores the word at the pointer and advances the pointer by one.
- R8: A stall response (`nl_rsp_kind`=1) loads the countdown with `nl_rsp_stall` and keeps the pointer. The retry asks for the same word, and earlier words are not requested again.
- R9: An error response (`nl_rsp_kind`=2) latches an error in the record, which stops fetching. The next lookup that misses on that set answers `rsp_kind`=3 and closes the record, so a later miss starts a fresh refill.
- R10: On the data response for the last word, the set's tag and data are written from the record, its valid bit is set and the record closes. A lookup in the following cycle hits.
- R11: After reset every line is invalid and no record is open. While `req_valid` is low, `rsp_kind` is 0 and no record is opened or closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup strobe |
| req_addr | input | 32 | Lookup byte address |
| rsp_kind | output | 2 | 0 none, 1 hit, 2 miss/retry, 3 error |
| rsp_data | output | 32 | Word returned on a hit |
| rsp_stall | output | CNT_W | Stall hint returned on a miss |
| nl_req_valid | output | 1 | One-cycle word request to the next level |
| nl_req_addr | output | 32 | Byte address of the requested word |
| nl_rsp_valid | input | 1 | Next-level response strobe |
| nl_rsp_kind | input | 2 | 0 data, 1 stall, 2 error |
| nl_rsp_data | input | 32 | Word returned with a data response |
| nl_rsp_stall | input | CNT_W | Stall count returned with a stall response |

## Verification
Some rules are checked by properties on every cycle. These cover the initial contents of a record after it opens, and the countdown dropping by one while idle. They also cover the pointer holding on a stall and advancing on data, a single outstanding request with a one-hot grant, and the line becoming valid with the new tag after a fill. Other behaviour can only be shown by the bench's scenarios, run against its own next-level memory. That includes the exact word address sequence with a repeated word after a stall, and the hit becoming visible exactly one cycle after the last word. It also includes the error reaching the requester and clearing the record, and a conflicting tag evicting a line.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_HIT  = 2'd1,
    RSP_MISS = 2'd2,
    RSP_ERR  = 2'd3
  } req_rsp_e;

  typedef enum logic [1:0] {
    NL_DATA  = 2'd0,
    NL_STALL = 2'd1,
    NL_ERR   = 2'd2
  } nl_rsp_e;

  // byte address of one word inside a line
  function automatic logic [31:0] word_addr(input logic [31:0] base, input logic [31:0] ptr);
    return base + (ptr << 2);
  endfunction

endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int SETS  = 8,
  parameter int WORDS = 4,
  parameter int TAG_W = 25,
  localparam int IDX_W = $clog2(SETS),
  localparam int PTR_W = $clog2(WORDS)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [SETS-1:0]                     wr_en,
  input  logic [SETS-1:0][TAG_W-1:0]          wr_tag,
  input  logic [SETS-1:0][WORDS-1:0][31:0]    wr_line,
  input  logic [IDX_W-1:0]                    rd_idx,
  input  logic [PTR_W-1:0]                    rd_off,
  output logic                                rd_valid,
  output logic [TAG_W-1:0]                    rd_tag,
  output logic [31:0]                         rd_word
);

  logic [SETS-1:0]                  valid_q;
  logic [SETS-1:0][TAG_W-1:0]       tag_q;
  logic [SETS-1:0][WORDS-1:0][31:0] data_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[s] <= 1'b0;
        tag_q[s]   <= '0;
        data_q[s]  <= '0;
      end else if (wr_en[s]) begin
        valid_q[s] <= 1'b1;
        tag_q[s]   <= wr_tag[s];
        data_q[s]  <= wr_line[s];
      end
    end

    // R10: a completed fill leaves the line valid with the record's tag
    p_fill_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[s] |=> valid_q[s] && (tag_q[s] == $past(wr_tag[s])));
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_word  = data_q[rd_idx][rd_off];

endmodule

// File: rtl/dmc_refill_slot.sv
module dmc_refill_slot
  import dmc_pkg::*;
#(
  parameter int WORDS      = 4,
  parameter int TAG_W      = 25,
  parameter int CNT_W      = 16,
  parameter int ACCESS_LAT = 3,
  localparam int PTR_W = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc,
  input  logic [31:0]            alloc_base,
  input  logic [TAG_W-1:0]       alloc_tag,
  input  logic                   clear_err,
  input  logic                   grant,
  input  logic                   rsp_hit,
  input  logic [1:0]             rsp_kind,
  input  logic [31:0]            rsp_data,
  input  logic [CNT_W-1:0]       rsp_stall,
  output logic                   pending,
  output logic                   errored,
  output logic                   eligible,
  output logic [CNT_W-1:0]       countdown,
  output logic [31:0]            fetch_addr,
  output logic [TAG_W-1:0]       fill_tag,
  output logic                   fill_done,
  output logic [WORDS-1:0][31:0] fill_line
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(WORDS - 1);
  localparam logic [CNT_W-1:0] LAT  = CNT_W'(ACCESS_LAT);

  logic                   pending_q, err_q, wait_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [PTR_W-1:0]       ptr_q;
  logic [31:0]            base_q;
  logic [TAG_W-1:0]       tag_q;
  logic [WORDS-1:0][31:0] wbuf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      err_q     <= 1'b0;
      wait_q    <= 1'b0;
      cnt_q     <= '0;
      ptr_q     <= '0;
      base_q    <= '0;
      tag_q     <= '0;
      wbuf_q    <= '0;
    end else if (alloc) begin
      pending_q <= 1'b1;
      err_q     <= 1'b0;
      wait_q    <= 1'b0;
      cnt_q     <= LAT;
      ptr_q     <= '0;
      base_q    <= alloc_base;
      tag_q     <= alloc_tag;
    end else if (clear_err) begin
      pending_q <= 1'b0;
      err_q     <= 1'b0;
    end else if (pending_q) begin
      if (rsp_hit) begin
        wait_q <= 1'b0;
        case (rsp_kind)
          NL_DATA: begin
            wbuf_q[ptr_q] <= rsp_data;
            if (ptr_q == LAST) pending_q <= 1'b0;
            else               ptr_q     <= ptr_q + PTR_W'(1);
          end
          NL_STALL: cnt_q <= rsp_stall;
          default:  err_q <= 1'b1;
        endcase
      end else if (!wait_q && cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
      if (grant) wait_q <= 1'b1;
    end
  end

  assign pending    = pending_q;
  assign errored    = err_q;
  assign countdown  = cnt_q;
  assign eligible   = pending_q && !err_q && !wait_q && (cnt_q == '0);
  assign fetch_addr = word_addr(base_q, 32'(ptr_q));
  assign fill_tag   = tag_q;
  assign fill_done  = pending_q && rsp_hit && (rsp_kind == NL_DATA) && (ptr_q == LAST);

  always_comb begin
    fill_line        = wbuf_q;
    fill_line[ptr_q] = rsp_data;
  end

  // R3: a fresh record starts at word 0 with the full latency and no error
  p_alloc_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> pending_q && (cnt_q == LAT) && (ptr_q == '0) && !err_q);

  // R5: an idle countdown drops by exactly one
  p_countdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q && !wait_q && (cnt_q != '0) && !rsp_hit && !alloc && !clear_err
    |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R5: the arbiter never grants a record that is still counting or failed
  p_no_early_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> pending_q && (cnt_q == '0) && !err_q && !wait_q);

  // R7: a data response moves the pointer forward by one
  p_data_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q && rsp_hit && (rsp_kind == NL_DATA) && (ptr_q != LAST) && !clear_err
    |=> ptr_q == $past(ptr_q) + PTR_W'(1));

  // R8: a stall keeps the pointer and reloads the countdown
  p_stall_resume_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q && rsp_hit && (rsp_kind == NL_STALL) && !clear_err
    |=> (ptr_q == $past(ptr_q)) && (cnt_q == $past(rsp_stall)));

endmodule

// File: rtl/dmc_fetch_arb.sv
module dmc_fetch_arb #(
  parameter int SETS = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SETS-1:0]  eligible,
  input  logic             nl_rsp_valid,
  output logic [SETS-1:0]  grant,
  output logic [SETS-1:0]  rsp_sel,
  output logic [IDX_W-1:0] pick,
  output logic             issue,
  output logic             busy
);

  logic             busy_q;
  logic [IDX_W-1:0] owner_q;

  // lowest eligible set index wins
  always_comb begin
    grant = '0;
    pick  = '0;
    for (int s = SETS - 1; s >= 0; s--) begin
      if (eligible[s]) pick = IDX_W'(s);
    end
    if (!busy_q && (eligible != '0)) grant[pick] = 1'b1;
  end

  assign issue = (grant != '0);
  assign busy  = busy_q;

  always_comb begin
    rsp_sel = '0;
    if (busy_q && nl_rsp_valid) rsp_sel[owner_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (issue) begin
      busy_q  <= 1'b1;
      owner_q <= pick;
    end else if (busy_q && nl_rsp_valid) begin
      busy_q  <= 1'b0;
    end
  end

  // R6: never a second request while one is outstanding
  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !issue);

  // R6: at most one record granted per cycle
  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6: an issued request stays outstanding until answered
  p_issue_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> busy_q && (owner_q == $past(pick)));

endmodule

// File: rtl/dmc_refill_cache.sv
module dmc_refill_cache
  import dmc_pkg::*;
#(
  parameter int SETS       = 8,
  parameter int WORDS      = 4,
  parameter int ACCESS_LAT = 3,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  output logic [1:0]       rsp_kind,
  output logic [31:0]      rsp_data,
  output logic [CNT_W-1:0] rsp_stall,
  output logic             nl_req_valid,
  output logic [31:0]      nl_req_addr,
  input  logic             nl_rsp_valid,
  input  logic [1:0]       nl_rsp_kind,
  input  logic [31:0]      nl_rsp_data,
  input  logic [CNT_W-1:0] nl_rsp_stall
);

  localparam int IDX_W = $clog2(SETS);
  localparam int PTR_W = $clog2(WORDS);
  localparam int OFF_W = PTR_W + 2;
  localparam int TAG_W = 32 - IDX_W - OFF_W;

  // R1: address field split
  function automatic logic [TAG_W-1:0] f_tag(input logic [31:0] a);
    return a[31 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] f_idx(input logic [31:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [PTR_W-1:0] f_word(input logic [31:0] a);
    return a[2 +: PTR_W];
  endfunction
  function automatic logic [31:0] f_base(input logic [31:0] a);
    return {a[31:OFF_W], {OFF_W{1'b0}}};
  endfunction

  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic [PTR_W-1:0] lk_word;
  logic             st_valid;
  logic [TAG_W-1:0] st_tag;
  logic [31:0]      st_word;
  logic             lk_hit;

  logic [SETS-1:0]                  alloc, clear_err, grant, rsp_sel;
  logic [SETS-1:0]                  slot_pend, slot_err, slot_elig, slot_done;
  logic [CNT_W-1:0]                 slot_cnt   [SETS];
  logic [31:0]                      slot_faddr [SETS];
  logic [SETS-1:0][TAG_W-1:0]       slot_tag;
  logic [SETS-1:0][WORDS-1:0][31:0] slot_line;
  logic [IDX_W-1:0]                 arb_pick;
  logic                             arb_busy;
  req_rsp_e                         kind_c;

  assign lk_idx  = f_idx(req_addr);
  assign lk_tag  = f_tag(req_addr);
  assign lk_word = f_word(req_addr);
  assign lk_hit  = st_valid && (st_tag == lk_tag);

  dmc_line_store #(.SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(slot_done), .wr_tag(slot_tag), .wr_line(slot_line),
    .rd_idx(lk_idx), .rd_off(lk_word),
    .rd_valid(st_valid), .rd_tag(st_tag), .rd_word(st_word)
  );

  for (genvar s = 0; s < SETS; s++) begin : g_slot
    dmc_refill_slot #(
      .WORDS(WORDS), .TAG_W(TAG_W), .CNT_W(CNT_W), .ACCESS_LAT(ACCESS_LAT)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc[s]), .alloc_base(f_base(req_addr)), .alloc_tag(lk_tag),
      .clear_err(clear_err[s]), .grant(grant[s]),
      .rsp_hit(rsp_sel[s]), .rsp_kind(nl_rsp_kind),
      .rsp_data(nl_rsp_data), .rsp_stall(nl_rsp_stall),
      .pending(slot_pend[s]), .errored(slot_err[s]), .eligible(slot_elig[s]),
      .countdown(slot_cnt[s]), .fetch_addr(slot_faddr[s]),
      .fill_tag(slot_tag[s]), .fill_done(slot_done[s]), .fill_line(slot_line[s])
    );
  end

  dmc_fetch_arb #(.SETS(SETS)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .eligible(slot_elig), .nl_rsp_valid(nl_rsp_valid),
    .grant(grant), .rsp_sel(rsp_sel), .pick(arb_pick),
    .issue(nl_req_valid), .busy(arb_busy)
  );

  assign nl_req_addr = slot_faddr[arb_pick];

  // requester response, all in the cycle of the request
  always_comb begin
    alloc     = '0;
    clear_err = '0;
    kind_c    = RSP_NONE;
    rsp_data  = '0;
    rsp_stall = '0;
    if (req_valid) begin
      if (lk_hit) begin
        kind_c   = RSP_HIT;
        rsp_data = st_word;
      end else if (slot_err[lk_idx]) begin
        kind_c            = RSP_ERR;
        clear_err[lk_idx] = 1'b1;
      end else if (slot_pend[lk_idx]) begin
        kind_c    = RSP_MISS;
        rsp_stall = slot_cnt[lk_idx];
      end else begin
        kind_c        = RSP_MISS;
        rsp_stall     = CNT_W'(ACCESS_LAT);
        alloc[lk_idx] = 1'b1;
      end
    end
  end

  assign rsp_kind = kind_c;

  // R9: reporting an error closes that set's record
  p_err_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (rsp_kind == RSP_ERR) |=> !slot_pend[$past(lk_idx)] && !slot_err[$past(lk_idx)]);

  // R11: an idle request port reports nothing
  p_idle_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> rsp_kind == RSP_NONE);

endmodule

// File: tb/sim_dmc_refill_cache.sv
module sim_dmc_refill_cache;

  localparam int CLK_P = 10;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [31:0]      req_addr = '0;
  logic [1:0]       rsp_kind;
  logic [31:0]      rsp_data;
  logic [CNT_W-1:0] rsp_stall;
  logic             nl_req_valid;
  logic [31:0]      nl_req_addr;
  logic             nl_rsp_valid = 1'b0;
  logic [1:0]       nl_rsp_kind = '0;
  logic [31:0]      nl_rsp_data = '0;
  logic [CNT_W-1:0] nl_rsp_stall = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  dmc_refill_cache #(.SETS(8), .WORDS(4), .ACCESS_LAT(3), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr),
    .rsp_kind(rsp_kind), .rsp_data(rsp_data), .rsp_stall(rsp_stall),
    .nl_req_valid(nl_req_valid), .nl_req_addr(nl_req_addr),
    .nl_rsp_valid(nl_rsp_valid), .nl_rsp_kind(nl_rsp_kind),
    .nl_rsp_data(nl_rsp_data), .nl_rsp_stall(nl_rsp_stall)
  );

  // next-level memory contents
  function automatic logic [31:0] memw(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  // next-level model: answers one cycle after it sees a request
  logic        have_req = 1'b0;
  logic [31:0] cap_addr = '0;
  logic        stall_arm = 1'b0, err_arm = 1'b0;
  logic [31:0] stall_addr = '0, err_addr = '0;
  logic [CNT_W-1:0] stall_cnt = '0;
  logic [31:0] log_a [64];
  int          log_n = 0;

  always @(negedge clk) begin
    if (have_req) begin
      nl_rsp_valid = 1'b1;
      if (stall_arm && cap_addr == stall_addr) begin
        nl_rsp_kind = 2'd1; nl_rsp_stall = stall_cnt; stall_arm = 1'b0;
      end else if (err_arm && cap_addr == err_addr) begin
        nl_rsp_kind = 2'd2;
      end else begin
        nl_rsp_kind = 2'd0; nl_rsp_data = memw(cap_addr);
      end
      have_req = 1'b0;
    end else begin
      nl_rsp_valid = 1'b0;
      if (rst_n && nl_req_valid) begin
        have_req = 1'b1;
        cap_addr = nl_req_addr;
        if (log_n < 64) log_a[log_n] = nl_req_addr;
        log_n++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] a, output logic [1:0] k,
                         output logic [31:0] d, output logic [CNT_W-1:0] st);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    #1;
    k = rsp_kind; d = rsp_data; st = rsp_stall;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // table: {expected kind, address}
  localparam logic [33:0] VEC [10] = '{
    {2'd1, 32'h0000_1230}, {2'd1, 32'h0000_1234}, {2'd1, 32'h0000_1238},
    {2'd1, 32'h0000_123C}, {2'd1, 32'h0000_2040}, {2'd1, 32'h0000_204C},
    {2'd1, 32'h0000_3054}, {2'd1, 32'h0000_0004}, {2'd1, 32'h0000_000C},
    {2'd2, 32'h0000_5230}
  };

  logic [1:0]       k;
  logic [31:0]      d;
  logic [CNT_W-1:0] st;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R11: reset state, idle port
    check("R11 idle kind", 32'(rsp_kind), 32'd0);
    check("R11 no request", 32'(nl_req_valid), 32'd0);

    // R2/R3: address 0 has tag 0 like the reset tag, but the line is invalid
    do_read(32'h0, k, d, st);
    check("R2 invalid line misses", 32'(k), 32'd2);
    check("R3 first stall hint", 32'(st), 32'd3);
    idle(20);
    do_read(32'h8, k, d, st);
    check("R10 set 0 filled", 32'(k), 32'd1);
    check("R1 word 2 of line 0", d, memw(32'h8));

    // plain fill, exact timing: R4, R5, R6, R10
    log_n = 0;
    do_read(32'h0000_1234, k, d, st);
    check("R3 miss kind", 32'(k), 32'd2);
    do_read(32'h0000_1238, k, d, st);
    check("R4 pending hint", 32'(st), 32'd3);
    idle(9);
    do_read(32'h0000_1230, k, d, st);
    check("R5 still missing one cycle before install", 32'(k), 32'd2);
    check("R4 hint at zero", 32'(st), 32'd0);
    do_read(32'h0000_1230, k, d, st);
    check("R10 hit right after last word", 32'(k), 32'd1);
    check("R6 request count", 32'(log_n), 32'd4);
    for (int i = 0; i < 4; i++)
      check("R6 word address order", log_a[i], 32'h0000_1230 + 32'(4 * i));

    // stall on word 1: R8
    log_n = 0;
    stall_addr = 32'h0000_2044; stall_cnt = 16'd4; stall_arm = 1'b1;
    do_read(32'h0000_2040, k, d, st);
    idle(16);
    do_read(32'h0000_2040, k, d, st);
    check("R8 not yet installed", 32'(k), 32'd2);
    do_read(32'h0000_2040, k, d, st);
    check("R8 installed after stall", 32'(k), 32'd1);
    check("R8 request count", 32'(log_n), 32'd5);
    check("R8 word0", log_a[0], 32'h0000_2040);
    check("R8 word1", log_a[1], 32'h0000_2044);
    check("R8 word1 retried", log_a[2], 32'h0000_2044);
    check("R8 word2", log_a[3], 32'h0000_2048);
    check("R8 word3", log_a[4], 32'h0000_204C);

    // error on word 2: R9
    err_addr = 32'h0000_3058; err_arm = 1'b1;
    do_read(32'h0000_3050, k, d, st);
    idle(9);
    do_read(32'h0000_3050, k, d, st);
    check("R9 error reported", 32'(k), 32'd3);
    err_arm = 1'b0;
    do_read(32'h0000_3050, k, d, st);
    check("R9 fresh refill after error", 32'(k), 32'd2);
    check("R9 fresh latency", 32'(st), 32'd3);
    idle(12);

    // table walk: R2, R7 data
    foreach (VEC[i]) begin
      do_read(VEC[i][31:0], k, d, st);
      check("R2 table kind", 32'(k), 32'(VEC[i][33:32]));
      if (VEC[i][33:32] == 2'd1) check("R7 table data", d, memw(VEC[i][31:0]));
    end

    // R10: conflicting tag replaced the line in set 3
    idle(12);
    do_read(32'h0000_523C, k, d, st);
    check("R10 new tag hits", 32'(k), 32'd1);
    check("R10 new tag data", d, memw(32'h0000_523C));
    do_read(32'h0000_1230, k, d, st);
    check("R2 evicted tag misses", 32'(k), 32'd2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule